// File: doc/BRIEF.md
# Row-Buffered Supercell Memory with Shared Address Pins

This block models a small dynamic-memory style storage array. The storage holds ROWS times COLS supercells, each WIDTH bits wide. One narrow address bus carries both the row number and the column number, one after the other. A row strobe copies a whole row from the array into an internal row buffer and makes it the open row. Each later column strobe picks one supercell of that buffer. A column strobe either returns the supercell on the data output or overwrites it, depending on the write enable.

Edits go to the row buffer first. They reach the array when the open row is closed or when a new row strobe replaces it. Any number of column accesses may follow a single row strobe. A column strobe with no open row is flagged as a protocol error. In the default configuration there are 4 rows and 4 columns of 8-bit supercells, 128 bits in all, on a 2-bit address bus.

Top module: `mux_addr_dram`

## Requirements
- R1: After reset no row is open, `rd_valid` and `proto_err` are 0, and every supercell holds 0.
- R2: A cycle with `row_stb`=1 opens the row numbered by `addr`. The supercells of that row then become readable through column strobes.
- R3: A cycle with `col_stb`=1 and `wr_en`=0 on an open row drives the supercell at column `addr` onto `rd_data`. At the next clock edge `rd_valid` goes to 1 for exactly one cycle for that strobe, so back-to-back strobes give back-to-back valid cycles.
- R4: A cycle with `col_stb`=1 and `wr_en`=1 on an open row replaces the supercell at column `addr` with `wr_data`. It does not raise `rd_valid`, and a later read of that supercell returns the new value.
- R5: Several column strobes may follow one row strobe. Each one addresses the same open row.
- R6: The row buffer is written back to its row when `close_row`=1 or when another row strobe arrives. Written data persists after the row is reopened, and supercells that were not written keep their values.
- R7: A column strobe with no open row sets `proto_err` to 1 for exactly one cycle. It does not raise `rd_valid`, and if `wr_en`=1 the write data is discarded.
- R8: When strobes coincide in one cycle, `row_stb` wins over `close_row`, and `close_row` wins over `col_stb`. The strobes that lose are ignored completely.
- R9: A row strobe naming the row that is already open keeps the buffered contents, including edits not yet written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb | input | 1 | Row strobe: `addr` holds a row number |
| col_stb | input | 1 | Column strobe: `addr` holds a column number |
| close_row | input | 1 | Writes back and closes the open row |
| wr_en | input | 1 | With `col_stb`: 1 writes, 0 reads |
| addr | input | AW | Shared row/column address |
| wr_data | input | WIDTH | Data for column writes |
| rd_data | output | WIDTH | Supercell returned by the last column read |
| rd_valid | output | 1 | One-cycle pulse after each column read |
| proto_err | output | 1 | One-cycle pulse after a column strobe with no open row |

## Verification
The hardest situation to reach is an edit that lives only in the row buffer at the moment the row is replaced or reopened. Write-back and reload then happen on the same clock edge. The stimulus writes a supercell and, with no close in between, strobes either the same row or a different one. It then strobes the first row again and reads the edited and unedited columns. Coinciding strobes are driven on purpose, so that the ignored column access can be seen to leave the stored data untouched.

// File: rtl/mxd_pkg.sv
package mxd_pkg;

    // Decoded access for one cycle, after strobe priority is applied.
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_ROW   = 2'd1,
        CMD_CLOSE = 2'd2,
        CMD_COL   = 2'd3
    } mxd_cmd_e;

endpackage

// File: rtl/mxd_cmd_decode.sv
module mxd_cmd_decode
    import mxd_pkg::*;
(
    input  logic     row_stb,
    input  logic     close_row,
    input  logic     col_stb,
    output mxd_cmd_e cmd
);

    // Row strobe over close, close over column.
    always_comb begin
        if (row_stb)        cmd = CMD_ROW;
        else if (close_row) cmd = CMD_CLOSE;
        else if (col_stb)   cmd = CMD_COL;
        else                cmd = CMD_IDLE;
    end

    always_comb begin
        assert_cmd_unique_R8 : assert (!(row_stb && cmd != CMD_ROW));
    end

endmodule

// File: rtl/mxd_cell_array.sv
module mxd_cell_array #(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int WIDTH = 8,
    localparam int RB   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int LINE = COLS * WIDTH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wb_en,
    input  logic [RB-1:0]   wb_row,
    input  logic [LINE-1:0] wb_line,
    input  logic [RB-1:0]   rd_row,
    output logic [LINE-1:0] rd_line
);

    logic [ROWS-1:0][LINE-1:0] mem_d, mem_q;

    // One write-back port; each row decodes its own select.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_comb begin
            mem_d[r] = mem_q[r];
            if (wb_en && wb_row == RB'(r)) begin
                mem_d[r] = wb_line;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rd_line = mem_q[rd_row];

endmodule

// File: rtl/mxd_row_buffer.sv
module mxd_row_buffer
    import mxd_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int WIDTH = 8,
    localparam int RB   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CB   = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int LINE = COLS * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mxd_cmd_e         cmd,
    input  logic [RB-1:0]    row_sel,
    input  logic [CB-1:0]    col_sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [LINE-1:0]  arr_line,
    output logic             wb_en,
    output logic [RB-1:0]    wb_row,
    output logic [LINE-1:0]  wb_line,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             proto_err
);

    typedef struct packed {
        logic                         open;
        logic [RB-1:0]                row;
        logic [COLS-1:0][WIDTH-1:0]   line;
        logic [WIDTH-1:0]             rdata;
        logic                         rvalid;
        logic                         err;
    } rb_state_t;

    rb_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.err    = 1'b0;
        wb_en       = 1'b0;
        unique case (cmd)
            CMD_ROW: begin
                wb_en     = st_q.open;
                st_d.open = 1'b1;
                st_d.row  = row_sel;
                // Reopening the open row keeps pending edits.
                if (!(st_q.open && st_q.row == row_sel)) begin
                    st_d.line = arr_line;
                end
            end
            CMD_CLOSE: begin
                wb_en     = st_q.open;
                st_d.open = 1'b0;
            end
            CMD_COL: begin
                if (!st_q.open) begin
                    st_d.err = 1'b1;
                end else if (wr_en) begin
                    st_d.line[col_sel] = wr_data;
                end else begin
                    st_d.rdata  = st_q.line[col_sel];
                    st_d.rvalid = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wb_row    = st_q.row;
    assign wb_line   = st_q.line;
    assign rd_data   = st_q.rdata;
    assign rd_valid  = st_q.rvalid;
    assign proto_err = st_q.err;

    assert_row_opens_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_ROW |=> st_q.open && st_q.row == $past(row_sel));

    assert_close_shuts_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_CLOSE |=> !st_q.open);

    assert_valid_cause_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd == CMD_COL && !wr_en && st_q.open));

    assert_err_cause_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(cmd == CMD_COL && !st_q.open) && !rd_valid);

    assert_writeback_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> st_q.open && (cmd == CMD_ROW || cmd == CMD_CLOSE));

endmodule

// File: rtl/mux_addr_dram.sv
module mux_addr_dram
    import mxd_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int WIDTH = 8,
    localparam int RB   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CB   = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int AW   = (RB > CB) ? RB : CB,
    localparam int LINE = COLS * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_stb,
    input  logic             col_stb,
    input  logic             close_row,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             proto_err
);

    mxd_cmd_e        cmd;
    logic            wb_en;
    logic [RB-1:0]   wb_row;
    logic [LINE-1:0] wb_line;
    logic [LINE-1:0] arr_line;
    logic [RB-1:0]   row_sel;
    logic [CB-1:0]   col_sel;

    assign row_sel = addr[RB-1:0];
    assign col_sel = addr[CB-1:0];

    mxd_cmd_decode u_dec (
        .row_stb   (row_stb),
        .close_row (close_row),
        .col_stb   (col_stb),
        .cmd       (cmd)
    );

    mxd_cell_array #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wb_en   (wb_en),
        .wb_row  (wb_row),
        .wb_line (wb_line),
        .rd_row  (row_sel),
        .rd_line (arr_line)
    );

    mxd_row_buffer #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .row_sel   (row_sel),
        .col_sel   (col_sel),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .arr_line  (arr_line),
        .wb_en     (wb_en),
        .wb_row    (wb_row),
        .wb_line   (wb_line),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .proto_err (proto_err)
    );

    assert_pulse_exclusive_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && proto_err));

    assert_row_blocks_col_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (row_stb || close_row) |=> !rd_valid && !proto_err);

endmodule

// File: tb/sim_mux_addr_dram.sv
module sim_mux_addr_dram;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 4, COLS = 4, WIDTH = 8, AW = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             row_stb = 1'b0, col_stb = 1'b0, close_row = 1'b0, wr_en = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] rd_data;
    logic             rd_valid, proto_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [WIDTH-1:0] model [ROWS][COLS];

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_addr_dram #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u0 (
        .clk(clk), .rst_n(rst_n), .row_stb(row_stb), .col_stb(col_stb),
        .close_row(close_row), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .proto_err(proto_err)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [WIDTH-1:0] pat(input int r, input int c, input int k);
        return WIDTH'((r * 37 + c * 11 + k * 29 + 3) & 8'hFF);
    endfunction

    task automatic open_row(input int r);
        row_stb = 1'b1; addr = AW'(r);
        @(negedge clk);
        row_stb = 1'b0;
    endtask

    task automatic shut();
        close_row = 1'b1;
        @(negedge clk);
        close_row = 1'b0;
    endtask

    task automatic col_write(input int c, input logic [WIDTH-1:0] d, input string req);
        col_stb = 1'b1; wr_en = 1'b1; addr = AW'(c); wr_data = d;
        @(negedge clk);
        col_stb = 1'b0; wr_en = 1'b0;
        check(!rd_valid && !proto_err, req, {rd_valid, proto_err}, 0);
    endtask

    task automatic col_read(input int c, input logic [WIDTH-1:0] exp, input string req);
        col_stb = 1'b1; wr_en = 1'b0; addr = AW'(c);
        @(negedge clk);
        col_stb = 1'b0;
        check(rd_valid == 1'b1, req, rd_valid, 1);
        check(rd_data == exp, req, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset outputs
        check(!rd_valid && !proto_err, "R1 reset outputs", {rd_valid, proto_err}, 0);

        // R7: column read with nothing open
        col_stb = 1'b1; addr = 2'd1;
        @(negedge clk);
        col_stb = 1'b0;
        check(proto_err && !rd_valid, "R7 err on closed read", {proto_err, rd_valid}, 2);
        @(negedge clk);
        check(!proto_err, "R7 err single cycle", proto_err, 0);

        // R1/R2/R5: every supercell is zero after reset; rows switch without close
        for (int r = 0; r < ROWS; r++) begin
            open_row(r);
            for (int c = 0; c < COLS; c++) begin
                col_read(c, '0, "R1 zero after reset");
                model[r][c] = '0;
            end
        end
        shut();

        // R4/R6: fill the whole array row by row
        for (int r = 0; r < ROWS; r++) begin
            open_row(r);
            for (int c = 0; c < COLS; c++) begin
                model[r][c] = pat(r, c, 0);
                col_write(c, model[r][c], "R4 write no valid");
            end
            shut();
        end

        // R6/R2/R3: read back in descending row order, reversed columns
        for (int r = ROWS - 1; r >= 0; r--) begin
            open_row(r);
            for (int c = COLS - 1; c >= 0; c--) begin
                col_read(c, model[r][c], "R6 persisted data");
                @(negedge clk);
                check(!rd_valid, "R3 valid one cycle", rd_valid, 0);
            end
        end
        shut();

        // R4/R5/R9: edits under one open row, then reopen the same row
        open_row(2);
        col_write(1, 8'hA5, "R4 write");
        model[2][1] = 8'hA5;
        col_read(1, 8'hA5, "R4 read own write");
        col_read(0, model[2][0], "R5 neighbour unchanged");
        col_write(3, 8'h3C, "R4 write");
        model[2][3] = 8'h3C;
        open_row(2);
        col_read(3, 8'h3C, "R9 reopen keeps edit");
        col_read(1, 8'hA5, "R9 reopen keeps edit");
        col_write(0, 8'h5A, "R4 write");
        model[2][0] = 8'h5A;
        open_row(3);
        col_read(2, model[3][2], "R6 other row intact");
        open_row(2);
        for (int c = 0; c < COLS; c++) col_read(c, model[2][c], "R6 writeback on row strobe");

        // R3: back-to-back reads give back-to-back valid pulses
        col_stb = 1'b1; wr_en = 1'b0; addr = 2'd0;
        @(negedge clk);
        check(rd_valid && rd_data == model[2][0], "R3 burst first", rd_data, model[2][0]);
        addr = 2'd3;
        @(negedge clk);
        col_stb = 1'b0;
        check(rd_valid && rd_data == model[2][3], "R3 burst second", rd_data, model[2][3]);
        @(negedge clk);
        check(!rd_valid, "R3 burst ends", rd_valid, 0);

        // R8: row strobe beats a coinciding column write
        open_row(1);
        row_stb = 1'b1; col_stb = 1'b1; wr_en = 1'b1; addr = 2'd0; wr_data = 8'hEE;
        @(negedge clk);
        row_stb = 1'b0; col_stb = 1'b0; wr_en = 1'b0;
        check(!rd_valid && !proto_err, "R8 column ignored", {rd_valid, proto_err}, 0);
        col_read(0, model[0][0], "R8 row 0 opened and unwritten");

        // R8: close beats a coinciding column write
        close_row = 1'b1; col_stb = 1'b1; wr_en = 1'b1; addr = 2'd0; wr_data = 8'h77;
        @(negedge clk);
        close_row = 1'b0; col_stb = 1'b0; wr_en = 1'b0;
        check(!rd_valid && !proto_err, "R8 close wins", {rd_valid, proto_err}, 0);
        col_stb = 1'b1; addr = 2'd0;
        @(negedge clk);
        col_stb = 1'b0;
        check(proto_err && !rd_valid, "R8 row closed after close", {proto_err, rd_valid}, 2);

        // R7: a write with nothing open is discarded
        col_stb = 1'b1; wr_en = 1'b1; addr = 2'd2; wr_data = 8'h99;
        @(negedge clk);
        col_stb = 1'b0; wr_en = 1'b0;
        check(proto_err && !rd_valid, "R7 err on closed write", {proto_err, rd_valid}, 2);

        // R6/R7/R8: final sweep of the whole array against the model
        for (int r = 0; r < ROWS; r++) begin
            open_row(r);
            for (int c = 0; c < COLS; c++) col_read(c, model[r][c], "R6 final sweep");
        end
        shut();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule